// File: doc/BRIEF.md
# SHA-256 Message Padding Unit

This block sits between a byte source and a SHA-256 compression core. It takes a message one byte per beat, with a flag on the beat that closes the message. It hands the core complete 512-bit blocks, one 32-bit word per transfer. Every full group of 64 input bytes is passed on unchanged. When the message ends, the unit adds the closing pattern: a 0x80 byte, zero fill, and the 64-bit count of message bits. If the last group leaves no room for the count, the unit sends one extra block.

A beat may carry no data byte (`in_keep` low). With `in_last` high, such a beat closes the message without adding a byte, which is also how an empty message is sent. The unit counts message bits across all blocks of a message. It restarts the count for the next message. While a block is being sent, input acceptance stops. The word on the output side waits for `out_ready`.

Top module: `sha256_pad_unit`

## Requirements
- R1: Every 64 data bytes that do not include the end of the message leave as one non-final block, in arrival order. Each word is packed big-endian: group byte 4w goes to bits 31:24 of word w, and byte 4w+3 goes to bits 7:0.
- R2: The byte position right after the last data byte holds 0x80.
- R3: When the final group holds n bytes with n at most 55, a single final block carries the data, the 0x80 byte, zero bytes up to byte 55, and the length field in bytes 56 to 63.
- R4: When n is 56 to 63, the block with the data and 0x80 is zero-filled to byte 63 and sent as non-final. It is followed by a final block of 56 zero bytes and the length field.
- R5: When the message fills its last group exactly (n = 64), the data block is sent as non-final. It is followed by a final block with 0x80 in byte 0, zeros through byte 55, and the length field.
- R6: The length field is the total message length in bits, as a 64-bit value. Byte 56 holds the most significant byte and byte 63 the least, so word 14 holds the upper half and word 15 the lower half.
- R7: A message made only of a beat with in_keep low and in_last high yields one final block: word 0 is 0x80000000 and all other words are zero.
- R8: in_ready is low for as long as any block is being sent. in_ready and out_valid are never high together.
- R9: While out_valid is high and out_ready is low, out_word holds steady. out_eob is high on word 15 of each block. out_final is high on every word of the final block of a message and on no other word.
- R10: After the final block, the bit count and the byte position restart from zero. A following message is padded using only its own length.
- R11: A beat with in_keep low and in_last low is accepted and changes neither the data nor the count.
- R12: After reset, in_ready is high and out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Unit accepts a beat this cycle |
| in_byte | input | 8 | Message byte |
| in_keep | input | 1 | Beat carries a data byte |
| in_last | input | 1 | Beat closes the message |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_word | output | 32 | Block word, big-endian packed |
| out_eob | output | 1 | Word is the 16th of its block |
| out_final | output | 1 | Word belongs to the last block of the message |

## Verification
The assertions assume that the consumer may hold out_ready low for any number of cycles. They also assume the source keeps each beat steady until it is accepted, and never sends more than 2^61 bytes in one message. The stimulus drives every beat at a falling edge and holds it until in_ready is seen high. It draws random message lengths from 0 to 200 bytes, inserts empty beats at random, and sometimes ends a message with an empty closing beat. It randomizes out_ready, so the no-ready stall is exercised at every word position. Directed lengths cover each remainder boundary around 55, 56, 63 and 64 bytes.

// File: rtl/sha256_pad_pkg.sv
package sha256_pad_pkg;

    localparam int BLK_BYTES  = 64;
    localparam int WORD_BYTES = 4;
    localparam int WORDS      = BLK_BYTES / WORD_BYTES;
    localparam int LEN_BYTES  = 8;
    localparam int LEN_POS    = BLK_BYTES - LEN_BYTES;
    localparam int IDX_W      = $clog2(BLK_BYTES + 1);
    localparam int WIDX_W     = $clog2(WORDS);
    localparam int LEN_W      = LEN_BYTES * 8;
    localparam int WORD_W     = WORD_BYTES * 8;
    localparam int BLK_W      = BLK_BYTES * 8;

    typedef logic [7:0]       byte_t;
    typedef logic [LEN_W-1:0] bitlen_t;
    typedef logic [IDX_W-1:0] pos_t;

    typedef enum logic {
        ST_FILL = 1'b0,
        ST_SEND = 1'b1
    } pad_state_e;

    typedef struct packed {
        logic final_blk;
        logic extra_pend;
        logic mark_first;
    } blk_plan_t;

    // k = 0 selects the most significant byte of the length
    function automatic byte_t len_byte(input bitlen_t len, input int k);
        return len[LEN_W-1-8*k -: 8];
    endfunction

    function automatic logic tail_fits(input pos_t n);
        return n < pos_t'(LEN_POS);
    endfunction

endpackage

// File: rtl/pad_bit_counter.sv
module pad_bit_counter
    import sha256_pad_pkg::*;
#(
    parameter int CNT_W = LEN_W,
    parameter int STEP  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] bits_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + CNT_W'(STEP);
        end
    end

    assign bits_o = cnt_q;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr) |=> (bits_o == $past(bits_o) + CNT_W'(STEP))); // R6

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
        clr |=> (bits_o == '0)); // R10

endmodule

// File: rtl/pad_block_store.sv
module pad_block_store
    import sha256_pad_pkg::*;
#(
    parameter int BYTES = BLK_BYTES,
    parameter int LPOS  = LEN_POS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               wr_en,
    input  pos_t               wr_idx,
    input  byte_t              wr_byte,
    input  logic               fin_en,
    input  pos_t               fin_pos,
    input  logic               fin_len,
    input  logic               extra_en,
    input  logic               extra_mark,
    input  bitlen_t            len,
    output logic [BYTES*8-1:0] blk_o
);

    byte_t mem_q [BYTES];

    always_ff @(posedge clk) begin
        for (int i = 0; i < BYTES; i++) begin
            if (rst || clr) begin
                mem_q[i] <= '0;
            end else if (extra_en) begin
                if (i == 0 && extra_mark) begin
                    mem_q[i] <= 8'h80;
                end else if (i >= LPOS) begin
                    mem_q[i] <= len_byte(len, i - LPOS);
                end else begin
                    mem_q[i] <= '0;
                end
            end else begin
                if (wr_en && wr_idx == pos_t'(i)) begin
                    mem_q[i] <= wr_byte;
                end
                if (fin_en && fin_pos == pos_t'(i)) begin
                    mem_q[i] <= 8'h80;
                end
                if (fin_en && fin_len && i >= LPOS) begin
                    mem_q[i] <= len_byte(len, i - LPOS);
                end
            end
        end
    end

    for (genvar g = 0; g < BYTES; g++) begin : g_pack
        assign blk_o[BYTES*8-1-8*g -: 8] = mem_q[g];
    end

    AST_MARK_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        fin_en |-> (fin_pos <= pos_t'(BYTES))); // R2

    AST_LEN_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        (fin_en && fin_len) |-> (fin_pos < pos_t'(LPOS))); // R3

endmodule

// File: rtl/pad_word_sender.sv
module pad_word_sender
    import sha256_pad_pkg::*;
#(
    parameter int NW = WORDS,
    parameter int WW = WORD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NW*WW-1:0] blk_i,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [WW-1:0]    out_word,
    output logic             out_eob,
    output logic             done
);

    localparam int IW = $clog2(NW);

    logic          busy_q;
    logic [IW-1:0] widx_q;

    assign out_valid = busy_q;
    assign out_eob   = busy_q && (widx_q == IW'(NW-1));
    assign done      = out_eob && out_ready;
    assign out_word  = blk_i[NW*WW-1 - WW*int'(widx_q) -: WW];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            widx_q <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            widx_q <= '0;
        end else if (busy_q && out_ready) begin
            widx_q <= widx_q + 1'b1;
            if (widx_q == IW'(NW-1)) begin
                busy_q <= 1'b0;
            end
        end
    end

    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word))); // R9

    AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> (!busy_q || done)); // R8

endmodule

// File: rtl/sha256_pad_unit.sv
module sha256_pad_unit
    import sha256_pad_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [7:0]  in_byte,
    input  logic        in_keep,
    input  logic        in_last,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_word,
    output logic        out_eob,
    output logic        out_final
);

    pad_state_e state_q;
    pos_t       idx_q;
    blk_plan_t  plan_q;
    bitlen_t    len_q;

    bitlen_t          bits;
    bitlen_t          total;
    bitlen_t          len_sel;
    pos_t             n_next;
    logic             acc;
    logic             fin_take;
    logic             full_take;
    logic             send_done;
    logic             send_start;
    logic             extra_load;
    logic [BLK_W-1:0] blk;

    assign in_ready   = (state_q == ST_FILL);
    assign acc        = in_valid && in_ready;
    assign n_next     = idx_q + pos_t'(in_keep);
    assign total      = bits + (in_keep ? bitlen_t'(8) : bitlen_t'(0));
    assign fin_take   = acc && in_last;
    assign full_take  = acc && !in_last && in_keep && (idx_q == pos_t'(BLK_BYTES-1));
    assign extra_load = send_done && plan_q.extra_pend;
    assign send_start = fin_take || full_take || extra_load;
    assign len_sel    = (state_q == ST_FILL) ? total : len_q;
    assign out_final  = out_valid && plan_q.final_blk;

    pad_bit_counter #(.CNT_W(LEN_W), .STEP(8)) cnt_i (
        .clk    (clk),
        .rst    (rst),
        .clr    (send_done && plan_q.final_blk),
        .inc    (acc && in_keep),
        .bits_o (bits)
    );

    pad_block_store #(.BYTES(BLK_BYTES), .LPOS(LEN_POS)) store_i (
        .clk        (clk),
        .rst        (rst),
        .clr        (send_done && !plan_q.extra_pend),
        .wr_en      (acc && in_keep),
        .wr_idx     (idx_q),
        .wr_byte    (in_byte),
        .fin_en     (fin_take),
        .fin_pos    (n_next),
        .fin_len    (tail_fits(n_next)),
        .extra_en   (extra_load),
        .extra_mark (plan_q.mark_first),
        .len        (len_sel),
        .blk_o      (blk)
    );

    pad_word_sender #(.NW(WORDS), .WW(WORD_W)) send_i (
        .clk       (clk),
        .rst       (rst),
        .start     (send_start),
        .blk_i     (blk),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_word  (out_word),
        .out_eob   (out_eob),
        .done      (send_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FILL;
            idx_q   <= '0;
            plan_q  <= '0;
            len_q   <= '0;
        end else begin
            case (state_q)
                ST_FILL: begin
                    if (fin_take) begin
                        state_q           <= ST_SEND;
                        idx_q             <= '0;
                        len_q             <= total;
                        plan_q.final_blk  <= tail_fits(n_next);
                        plan_q.extra_pend <= !tail_fits(n_next);
                        plan_q.mark_first <= (n_next == pos_t'(BLK_BYTES));
                    end else if (full_take) begin
                        state_q <= ST_SEND;
                        idx_q   <= '0;
                        plan_q  <= '0;
                    end else if (acc && in_keep) begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_SEND: begin
                    if (send_done) begin
                        if (plan_q.extra_pend) begin
                            plan_q.extra_pend <= 1'b0;
                            plan_q.final_blk  <= 1'b1;
                        end else begin
                            state_q <= ST_FILL;
                            plan_q  <= '0;
                        end
                    end
                end
                default: state_q <= ST_FILL;
            endcase
        end
    end

    AST_NO_IN_DURING_OUT: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid)); // R8

    AST_EXTRA_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        extra_load |=> (out_valid && out_final)); // R4

    AST_RESTART_AFTER_FINAL: assert property (@(posedge clk) disable iff (rst)
        (send_done && plan_q.final_blk) |=> (in_ready && idx_q == '0)); // R10

endmodule

// File: tb/sha256_pad_unit_tb_top.sv
module sha256_pad_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_MSG    = 200;
    localparam int MAX_W      = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_byte = '0;
    logic        in_keep = 1'b0;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_word;
    logic        out_eob;
    logic        out_final;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [7:0]  msg [MAX_MSG];
    int          msg_len;
    int          msg_no = 0;
    logic [31:0] exp_w [MAX_W];
    logic [31:0] rx_w  [MAX_W];
    int          exp_n;
    int          ign_cnt;
    bit          tail_empty;

    always #(CLK_PERIOD/2) clk = ~clk;

    sha256_pad_unit dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
        .in_keep(in_keep), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
        .out_eob(out_eob), .out_final(out_final)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s msg=%0d len=%0d actual=%h expected=%h", tag, msg_no, msg_len, act, exp);
        end
    endtask

    function automatic void build_expected();
        logic [7:0]  pb [MAX_W*4];
        logic [63:0] nbits;
        int          nb;
        nb    = (msg_len + 72) / 64;
        nbits = 64'(msg_len) * 64'd8;
        for (int i = 0; i < MAX_W*4; i++) pb[i] = 8'h00;
        for (int i = 0; i < msg_len; i++) pb[i] = msg[i];
        pb[msg_len] = 8'h80;
        for (int k = 0; k < 8; k++) pb[nb*64-8+k] = nbits[63-8*k -: 8];
        exp_n = nb * 16;
        for (int w = 0; w < exp_n; w++)
            exp_w[w] = {pb[4*w], pb[4*w+1], pb[4*w+2], pb[4*w+3]};
    endfunction

    function automatic string pick_tag(input int w);
        int full;
        int r;
        full = (msg_len / 64) * 64;
        r    = msg_len - full;
        if (msg_len == 0) return "R7";
        if (w >= exp_n - 2) return (msg_no > 0) ? "R6/R10" : "R6";
        if (4*w + 3 < full) return (ign_cnt > 0) ? "R1/R11" : "R1";
        if (r == 0) return "R5";
        if (r < 56) return "R3";
        return "R4";
    endfunction

    task automatic send_beat(input bit keep, input bit last, input logic [7:0] b);
        in_valid = 1'b1;
        in_keep  = keep;
        in_last  = last;
        in_byte  = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_keep  = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic drive_msg();
        for (int i = 0; i < msg_len; i++) begin
            if ($urandom % 8 == 0) begin
                // R11: empty non-closing beat must not disturb data or count
                send_beat(1'b0, 1'b0, 8'($urandom));
                ign_cnt++;
            end
            if ($urandom % 4 == 0) @(negedge clk);
            send_beat(1'b1, (i == msg_len-1) && !tail_empty, msg[i]);
        end
        if (msg_len == 0 || tail_empty) send_beat(1'b0, 1'b1, 8'($urandom));
    endtask

    task automatic collect();
        int          rx_n = 0;
        bit          held = 1'b0;
        logic [31:0] held_word = '0;
        while (rx_n < exp_n) begin
            @(negedge clk);
            check(!(in_ready && out_valid), "R8", {62'd0, in_ready, out_valid}, 64'd0);
            if (held) begin
                check(out_valid && out_word == held_word, "R9 stall", 64'(out_word), 64'(held_word));
            end
            out_ready = ($urandom % 4 != 0);
            if (out_valid && out_ready) begin
                rx_w[rx_n] = out_word;
                check(out_eob == (rx_n % 16 == 15), "R9 eob", 64'(out_eob), 64'(rx_n % 16 == 15));
                check(out_final == (rx_n / 16 == exp_n / 16 - 1), "R9 final", 64'(out_final),
                      64'(rx_n / 16 == exp_n / 16 - 1));
                rx_n++;
                held = 1'b0;
            end else if (out_valid) begin
                held      = 1'b1;
                held_word = out_word;
            end else begin
                held = 1'b0;
            end
        end
    endtask

    task automatic run_msg();
        ign_cnt = 0;
        build_expected();
        fork
            drive_msg();
            collect();
        join
        for (int w = 0; w < exp_n; w++)
            check(rx_w[w] === exp_w[w], pick_tag(w), 64'(rx_w[w]), 64'(exp_w[w]));
        msg_no++;
    endtask

    task automatic fill_random(input int len);
        msg_len = len;
        for (int i = 0; i < len; i++) msg[i] = 8'($urandom);
    endtask

    initial begin
        int dir_len [10] = '{0, 55, 56, 63, 64, 65, 119, 120, 128, 191};
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready === 1'b1, "R12 in_ready", 64'(in_ready), 64'd1);
        check(out_valid === 1'b0, "R12 out_valid", 64'(out_valid), 64'd0);

        msg_len = 3;
        msg[0] = 8'h61; msg[1] = 8'h62; msg[2] = 8'h63;
        tail_empty = 1'b0;
        run_msg();
        check(rx_w[0] === 32'h61626380, "R2", 64'(rx_w[0]), 64'h61626380);
        check(rx_w[15] === 32'd24, "R6", 64'(rx_w[15]), 64'd24);

        foreach (dir_len[k]) begin
            fill_random(dir_len[k]);
            tail_empty = (k % 3 == 1);
            run_msg();
        end

        for (int t = 0; t < 20; t++) begin
            fill_random(int'($urandom % (MAX_MSG + 1)));
            tail_empty = ($urandom % 3 == 0);
            run_msg();
        end

        @(negedge clk);
        out_ready = 1'b0;
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired msg=%0d actual=hung expected=done", msg_no);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule